// File: doc/BRIEF.md
# Paced Byte Output Port with Ready Interrupt

This block is a memory-mapped byte sink standing in for a slow character display that can take only one byte per second. While it can accept a byte it holds its interrupt request high. A bus write that lands while the port is ready passes the low data byte to the display side as a one-clock strobe, and then starts a busy interval of `CLK_HZ` clock cycles. Once the interval ends, the port is ready again and raises its request. A write that arrives during the busy interval is acknowledged on the bus but goes nowhere.

A bus read serves only as an interrupt acknowledge. It returns zero and drops the request. The port can still accept a byte after a read, but the request does not come back by itself. It returns only after a new byte has been written and the full busy interval has run. Address decoding happens outside the block (the system decodes its select from one high address line), and the interrupt output goes to a priority encoder elsewhere.

The control sits in a three-state machine:
- `ST_REQ`: ready, request high.
- `ST_QUIET`: ready, request cleared by a read.
- `ST_BUSY`: interval running.

Its transitions are:
- `ST_REQ` to `ST_BUSY` on an accepted write.
- `ST_REQ` to `ST_QUIET` on a read.
- `ST_QUIET` to `ST_BUSY` on an accepted write.
- `ST_BUSY` to `ST_REQ` when the interval counter expires.

Every other input leaves the state where it is.

Top module: `slow_port`

## Requirements
- R1: After reset the port is ready. `irq` is 1, and `ack` and `disp_valid` are 0.
- R2: A write (`cs`=1, `wr`=1) captured at a clock edge while the port is ready has three effects after that edge: `disp_valid` is 1 for exactly one cycle, `disp_byte` equals `wdata`, and `irq` is 0.
- R3: A write captured at any of the `CLK_HZ` edges that follow an accepted write is dropped. `disp_valid` stays 0 and `disp_byte` keeps its value.
- R4: If a write is accepted at edge k, `irq` is 0 after edges k through k+`CLK_HZ`-1 and returns to 1 after edge k+`CLK_HZ`, provided no read intervenes.
- R5: A read (`cs`=1, `rd`=1, `wr`=0) returns `rdata` = 0 and clears `irq` after its edge. The port stays ready, so the next write is accepted.
- R6: Once a read has cleared `irq`, it stays 0 however long the port sits idle and however many further reads arrive. It returns only `CLK_HZ` edges after a later accepted write.
- R7: `ack` is 1 in the cycle after every edge at which `cs` and (`rd` or `wr`) are both high, dropped writes included. Otherwise `ack` is 0.
- R8: Strobes with `cs`=0 have no effect. There is no `ack`, no `disp_valid`, and `irq` is unchanged.
- R9: When `rd` and `wr` are both high, the access is treated as a write and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select from the external address decode |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data byte (low lane of the bus) |
| rdata | output | 8 | Read data, always zero |
| ack | output | 1 | Data acknowledge, one cycle after a selected access |
| irq | output | 1 | Ready interrupt request |
| disp_valid | output | 1 | One-cycle strobe of a byte sent to the display |
| disp_byte | output | 8 | Last byte sent to the display |

## Verification
The bench builds the port with `CLK_HZ` = 8, so one "second" lasts eight cycles. With that value the bench can see the request come back at the exact edge after each accepted write, and it can see reads hold the request low for two full intervals. The short interval also makes it practical to aim a write at the last busy edge and at the first ready edge, and to check the drop/accept boundary in both directions.

// File: rtl/slow_port_pkg.sv
package slow_port_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_REQ   = 2'd0,
        ST_QUIET = 2'd1,
        ST_BUSY  = 2'd2
    } port_state_e;

endpackage

// File: rtl/slow_port_fsm.sv
module slow_port_fsm
    import slow_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic rd,
    input  logic wr,
    input  logic expire,
    output logic accept,
    output logic busy,
    output logic irq
);

    port_state_e state_q;
    port_state_e state_d;

    logic wr_req;
    logic rd_req;

    assign wr_req = cs & wr;
    assign rd_req = cs & rd & ~wr;   // a write wins over a read

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_REQ;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        busy    = 1'b0;
        irq     = 1'b0;
        unique case (state_q)
            ST_REQ: begin
                irq = 1'b1;
                if (wr_req) begin
                    accept  = 1'b1;
                    state_d = ST_BUSY;
                end else if (rd_req) begin
                    state_d = ST_QUIET;
                end
            end
            ST_QUIET: begin
                if (wr_req) begin
                    accept  = 1'b1;
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                busy = 1'b1;
                if (expire) begin
                    state_d = ST_REQ;
                end
            end
            default: begin
                state_d = ST_REQ;
            end
        endcase
    end

endmodule

// File: rtl/slow_port_timer.sv
module slow_port_timer #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CLK_HZ - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && (cnt_q == '0);

endmodule

// File: rtl/slow_port_bus.sv
module slow_port_bus
    import slow_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic              accept,
    input  logic [BYTE_W-1:0] wdata,
    output logic              ack,
    output logic              disp_valid,
    output logic [BYTE_W-1:0] disp_byte
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack        <= 1'b0;
            disp_valid <= 1'b0;
            disp_byte  <= '0;
        end else begin
            ack        <= cs & (rd | wr);
            disp_valid <= accept;
            if (accept) begin
                disp_byte <= wdata;
            end
        end
    end

endmodule

// File: rtl/slow_port.sv
module slow_port
    import slow_port_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              ack,
    output logic              irq,
    output logic              disp_valid,
    output logic [BYTE_W-1:0] disp_byte
);

    logic accept;
    logic busy;
    logic expire;

    slow_port_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (cs),
        .rd     (rd),
        .wr     (wr),
        .expire (expire),
        .accept (accept),
        .busy   (busy),
        .irq    (irq)
    );

    slow_port_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .run    (busy),
        .expire (expire)
    );

    slow_port_bus u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .rd         (rd),
        .wr         (wr),
        .accept     (accept),
        .wdata      (wdata),
        .ack        (ack),
        .disp_valid (disp_valid),
        .disp_byte  (disp_byte)
    );

    // reads only acknowledge the interrupt; the data is always zero
    assign rdata = '0;

endmodule

// File: rtl/slow_port_chk.sv
module slow_port_chk
    import slow_port_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              rd,
    input logic              wr,
    input logic              ack,
    input logic              irq,
    input logic              disp_valid,
    input logic [BYTE_W-1:0] disp_byte
);

    localparam int GW = $clog2(CLK_HZ + 2) + 1;
    localparam logic [GW-1:0] N_G   = GW'(CLK_HZ);
    localparam logic [GW-1:0] SAT_G = GW'(CLK_HZ + 1);

    // cycles since the last display strobe, saturating; 0 = none yet
    logic [GW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (disp_valid) begin
            gap <= GW'(1);
        end else if ((gap != '0) && (gap != SAT_G)) begin
            gap <= gap + 1'b1;
        end
    end

    AST_WRITE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && irq) |=> (!irq && disp_valid)); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid); // R2

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && (disp_valid || ((gap != '0) && (gap < N_G))))
            |=> (!disp_valid && $stable(disp_byte))); // R3

    AST_IRQ_RETURN_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (gap == N_G)); // R4

    AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !wr) |=> !irq); // R5

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !disp_valid && ((gap == '0) || (gap == SAT_G))) |=> !irq); // R6

    AST_ACK_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && (rd || wr)) |=> ack); // R7

    AST_NO_ACK_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && (rd || wr)) |=> !ack); // R8

endmodule

bind slow_port slow_port_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .rd         (rd),
    .wr         (wr),
    .ack        (ack),
    .irq        (irq),
    .disp_valid (disp_valid),
    .disp_byte  (disp_byte)
);

// File: tb/slow_port_test.sv
`timescale 1ns/1ps
module slow_port_test;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ack;
    logic       irq;
    logic       disp_valid;
    logic [7:0] disp_byte;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // results sampled at the negedge after an access
    logic       o_ack, o_irq, o_valid;
    logic [7:0] o_byte, o_rdata;
    int         o_edge;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    slow_port #(.CLK_HZ(N)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .wdata(wdata),
        .rdata(rdata), .ack(ack), .irq(irq), .disp_valid(disp_valid),
        .disp_byte(disp_byte)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // called at a negedge: drive, wait one edge, sample at the next negedge
    task automatic bus_op(input logic c, input logic r, input logic w, input logic [7:0] d);
        cs = c; rd = r; wr = w; wdata = d;
        @(negedge clk);
        o_ack = ack; o_irq = irq; o_valid = disp_valid;
        o_byte = disp_byte; o_rdata = rdata; o_edge = cyc;
        cs = 1'b0; rd = 1'b0; wr = 1'b0; wdata = 8'h00;
    endtask

    // accepted write at edge k: irq low after edge k+N-1, high after edge k+N
    task automatic check_return(input string req, input int k);
        while (cyc < k + N - 1) @(negedge clk);
        chk(req, "irq on last busy cycle", int'(irq), 0);
        @(negedge clk);
        chk(req, "irq back after interval", int'(irq), 1);
    endtask

    task automatic t_reset();
        chk("R1", "irq after reset", int'(irq), 1);
        chk("R1", "ack after reset", int'(ack), 0);
        chk("R1", "disp_valid after reset", int'(disp_valid), 0);
    endtask

    task automatic t_write_basic();
        int k;
        bus_op(1'b1, 1'b0, 1'b1, 8'hA5);
        k = o_edge;
        chk("R2", "valid on accepted write", int'(o_valid), 1);
        chk("R2", "byte on accepted write", int'(o_byte), 'hA5);
        chk("R2", "irq after accepted write", int'(o_irq), 0);
        chk("R7", "ack on write", int'(o_ack), 1);
        @(negedge clk);
        chk("R2", "valid lasts one cycle", int'(disp_valid), 0);
        chk("R7", "ack lasts one cycle", int'(ack), 0);
        check_return("R4", k);
    endtask

    task automatic t_busy_drop();
        int k;
        bus_op(1'b1, 1'b0, 1'b1, 8'h11);
        k = o_edge;
        chk("R2", "first byte accepted", int'(o_byte), 'h11);
        bus_op(1'b1, 1'b0, 1'b1, 8'h22);
        chk("R3", "busy write no valid", int'(o_valid), 0);
        chk("R3", "busy write keeps byte", int'(o_byte), 'h11);
        chk("R7", "ack on dropped write", int'(o_ack), 1);
        // last busy edge is k+N: aim a write there
        while (cyc < k + N - 1) @(negedge clk);
        bus_op(1'b1, 1'b0, 1'b1, 8'h44);
        chk("R3", "last-busy-edge write no valid", int'(o_valid), 0);
        chk("R3", "last-busy-edge write keeps byte", int'(o_byte), 'h11);
        chk("R4", "irq back despite dropped writes", int'(o_irq), 1);
        // first ready edge: accepted
        bus_op(1'b1, 1'b0, 1'b1, 8'h33);
        k = o_edge;
        chk("R2", "first ready edge write valid", int'(o_valid), 1);
        chk("R2", "first ready edge write byte", int'(o_byte), 'h33);
        check_return("R4", k);
    endtask

    task automatic t_read_ack();
        int k;
        bus_op(1'b1, 1'b1, 1'b0, 8'hFF);
        chk("R5", "read data zero", int'(o_rdata), 0);
        chk("R5", "irq cleared by read", int'(o_irq), 0);
        chk("R7", "ack on read", int'(o_ack), 1);
        chk("R5", "read gives no valid", int'(o_valid), 0);
        repeat (2 * N) @(negedge clk);
        chk("R6", "irq stays low while idle", int'(irq), 0);
        bus_op(1'b1, 1'b1, 1'b0, 8'h00);
        chk("R6", "irq low after second read", int'(o_irq), 0);
        chk("R5", "second read data zero", int'(o_rdata), 0);
        bus_op(1'b1, 1'b0, 1'b1, 8'h5A);
        k = o_edge;
        chk("R5", "write after read accepted", int'(o_valid), 1);
        chk("R5", "write after read byte", int'(o_byte), 'h5A);
        check_return("R6", k);
    endtask

    task automatic t_no_cs();
        bus_op(1'b0, 1'b0, 1'b1, 8'hC3);
        chk("R8", "unselected write no ack", int'(o_ack), 0);
        chk("R8", "unselected write no valid", int'(o_valid), 0);
        chk("R8", "unselected write irq kept", int'(o_irq), 1);
        chk("R8", "unselected write byte kept", int'(o_byte), 'h5A);
        bus_op(1'b0, 1'b1, 1'b0, 8'h00);
        chk("R8", "unselected read no ack", int'(o_ack), 0);
        chk("R8", "unselected read irq kept", int'(o_irq), 1);
    endtask

    task automatic t_rd_wr_both();
        int k;
        bus_op(1'b1, 1'b1, 1'b1, 8'h7E);
        k = o_edge;
        chk("R9", "rd+wr acts as write valid", int'(o_valid), 1);
        chk("R9", "rd+wr acts as write byte", int'(o_byte), 'h7E);
        chk("R9", "rd+wr ack", int'(o_ack), 1);
        // read ignored: irq returns after the interval as for a plain write
        check_return("R9", k);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_busy_drop();
        t_read_ack();
        t_no_cs();
        t_rd_wr_both();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule